// File: doc/BRIEF.md
# Four-Beat Aligned Line Burst Master

This block is the bus-master side of a synchronous 32-bit memory bus. It moves one 16-byte line at a time. Every input is sampled on the rising edge of a single clock. A client hands over a line request made of a byte address, a direction, a critical-word index and, for writes, the whole 128-bit line. The controller forces the address down to the 16-byte boundary. It then drives an active-low burst indicator and runs four beats. The first beat carries the requested critical word, and the later beats wrap round the line modulo four. A beat completes only on a cycle where the slave acknowledges it, so any number of wait states can be inserted.

If the slave reports burst inhibit while acknowledging the first beat, that beat still completes. The remaining three words are then moved as separate single transfers, with the burst indicator released and one idle bus cycle before each one. A slave error ends the line at once and raises an error flag; nothing is retried. Arbitration is handled elsewhere, and the bus is assumed to be already owned. When the line ends, a one-cycle completion pulse appears together with the collected read line and the error flag.

Top module: `burst_line_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `bus_valid` is 0, `bus_burst_n` is 1 and `line_done` is 0.
- R2: Every bus address carries the requested address bits [25:4] unchanged, and bits [1:0] are zero, whatever the low four bits of `req_addr` were.
- R3: Beat k of a line (k = 0..3) addresses word (crit + k) mod 4, and that word index sits in `bus_addr[3:2]`.
- R4: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. In the next cycle `bus_valid` is 1 and `bus_burst_n` is 0, and `bus_burst_n` stays 0 for every beat of a burst that is not inhibited.
- R5: While a beat waits (`bus_valid` 1 and neither `bus_ack` nor `bus_err` sampled), the address, direction, burst indicator and write data stay stable.
- R6: If `bus_binh` is 1 on the cycle that acknowledges the first beat of a burst, that beat completes. Each remaining word then goes out as a single beat with `bus_burst_n` 1, and each such beat follows one cycle with `bus_valid` 0.
- R7: `bus_binh` has no effect on a cycle without acknowledge, and no effect on any beat after the first; the burst continues with `bus_burst_n` 0.
- R8: For a read line that completes without error, `line_rdata[32*i+31:32*i]` holds the `bus_rdata` value acknowledged on the beat that addressed word i.
- R9: For a write line, `bus_we` is 1 on every beat, and `bus_wdata` equals `req_wdata[32*i+31:32*i]` on the beat that addresses word i.
- R10: `bus_err` sampled during a beat ends the line and wins over a simultaneous `bus_ack`. No further beat is issued, and `line_err` is 1 with the completion pulse.
- R11: `line_done` is 1 for exactly the one cycle after the final acknowledge or the error. `req_ready` is 1 only while idle, so requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_addr | input | 26 | Byte address of the line (low 4 bits ignored) |
| req_crit | input | 2 | Index of the critical word within the line |
| req_wdata | input | 128 | Write line, word i in bits [32*i+31:32*i] |
| line_done | output | 1 | One-cycle completion pulse |
| line_err | output | 1 | Line ended by a slave error (valid with line_done) |
| line_rdata | output | 128 | Collected read line, word i in bits [32*i+31:32*i] |
| bus_valid | output | 1 | A beat is being offered on the bus |
| bus_addr | output | 26 | Byte address of the current beat |
| bus_burst_n | output | 1 | Active-low burst indicator |
| bus_we | output | 1 | Beat direction, 1 = write |
| bus_wdata | output | 32 | Write data of the current beat |
| bus_rdata | input | 32 | Read data from the slave |
| bus_ack | input | 1 | Slave transfer acknowledge |
| bus_binh | input | 1 | Slave burst inhibit |
| bus_err | input | 1 | Slave error termination |

## Verification
Two events can land on one clock edge: the acknowledge that completes the first beat and the slave's burst-inhibit report, which must turn the rest of the line into single beats. The bench provokes this in three ways. It raises inhibit together with the first acknowledge after zero and after several wait states. It raises inhibit only during the wait cycles. It raises inhibit on the second beat. A behavioural model then predicts, for every clock, the burst indicator, the idle gaps and the address order. The same model also covers an error that arrives on the same edge as an acknowledge and as the inhibit, where the error has to win.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } bst_state_e;

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_crit,
  input  logic             bus_ack,
  input  logic             bus_binh,
  input  logic             bus_err,
  output bst_state_e       state,
  output logic             accept,
  output logic             in_beat,
  output logic             beat_done,
  output logic             term_err,
  output logic             fallback,
  output logic             last_beat,
  output logic             burst_on,
  output logic [IDX_W-1:0] word_idx
);

  // word index of beat b when the line starts at word c (wraps in the line)
  function automatic logic [IDX_W-1:0] wrap_word(input logic [IDX_W-1:0] c,
                                                 input logic [IDX_W-1:0] b);
    return c + b;
  endfunction

  bst_state_e       st_q;
  logic [IDX_W-1:0] beat_q;
  logic [IDX_W-1:0] crit_q;
  logic             burst_q;

  assign state     = st_q;
  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign in_beat   = (st_q == ST_BEAT);
  assign term_err  = in_beat && bus_err;
  assign beat_done = in_beat && bus_ack && !bus_err;
  assign fallback  = beat_done && burst_q && (beat_q == '0) && bus_binh;
  assign last_beat = (beat_q == IDX_W'(BEATS - 1));
  assign burst_on  = burst_q;
  assign word_idx  = wrap_word(crit_q, beat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      crit_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q    <= ST_BEAT;
            beat_q  <= '0;
            crit_q  <= req_crit;
            burst_q <= 1'b1;
          end
        end
        ST_BEAT: begin
          if (term_err) begin
            st_q <= ST_DONE;
          end else if (beat_done) begin
            if (fallback) burst_q <= 1'b0;
            if (last_beat) begin
              st_q <= ST_DONE;
            end else begin
              beat_q <= beat_q + IDX_W'(1);
              st_q   <= (burst_q && !fallback) ? ST_BEAT : ST_GAP;
            end
          end
        end
        ST_GAP:  st_q <= ST_BEAT;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  fallback_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback && !last_beat |=> (st_q == ST_GAP) && !burst_q);

  // R7
  late_binh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && (beat_q != '0) && burst_q && bus_binh && !last_beat
    |=> (st_q == ST_BEAT) && burst_q);

  // R10
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_err |=> (st_q == ST_DONE));

  // R11
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));

  // R3
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !last_beat |=> word_idx == $past(word_idx) + IDX_W'(1));

endmodule

// File: rtl/burst_dpath.sv
module burst_dpath #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 26,
  parameter int BEATS  = 4,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    req_write,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic [DATA_W*BEATS-1:0] req_wdata,
  input  logic                    beat_done,
  input  logic                    term_err,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic                    bus_we,
  output logic [DATA_W*BEATS-1:0] line_rdata,
  output logic                    line_err
);

  // byte address of a word inside an aligned line
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [TAG_W-1:0] tag,
                                                  input logic [IDX_W-1:0] idx);
    return {tag, idx, {OFF_W{1'b0}}};
  endfunction

  logic [TAG_W-1:0]  tag_q;
  logic              we_q;
  logic              err_q;
  logic [DATA_W-1:0] wword [BEATS];
  logic [DATA_W-1:0] rword [BEATS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      we_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (accept) begin
      tag_q <= req_tag;
      we_q  <= req_write;
      err_q <= 1'b0;
    end else if (term_err) begin
      err_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < BEATS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wword[i] <= '0;
        rword[i] <= '0;
      end else begin
        if (accept) wword[i] <= req_wdata[i*DATA_W +: DATA_W];
        if (beat_done && !we_q && (word_idx == IDX_W'(i))) rword[i] <= bus_rdata;
      end
    end
    assign line_rdata[i*DATA_W +: DATA_W] = rword[i];
  end

  assign bus_addr  = beat_addr(tag_q, word_idx);
  assign bus_wdata = wword[word_idx];
  assign bus_we    = we_q;
  assign line_err  = err_q;

  // R8
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !we_q |=> rword[$past(word_idx)] == $past(bus_rdata));

  // R2
  line_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bus_addr[ADDR_W-1:OFF_W+IDX_W] == $past(req_tag));

  // R10
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_err |=> line_err);

endmodule

// File: rtl/burst_line_ctrl.sv
module burst_line_ctrl
  import burst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 26,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [$clog2(BEATS)-1:0] req_crit,
  input  logic [DATA_W*BEATS-1:0] req_wdata,
  output logic                    line_done,
  output logic                    line_err,
  output logic [DATA_W*BEATS-1:0] line_rdata,
  output logic                    bus_valid,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_burst_n,
  output logic                    bus_we,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    bus_ack,
  input  logic                    bus_binh,
  input  logic                    bus_err
);

  localparam int IDX_W = $clog2(BEATS);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int LOW_W = IDX_W + OFF_W;
  localparam int TAG_W = ADDR_W - LOW_W;

  bst_state_e       state;
  logic             accept, in_beat, beat_done, term_err;
  logic             fallback, last_beat, burst_on;
  logic [IDX_W-1:0] word_idx;
  logic [LOW_W-1:0] unused_low_addr;

  assign unused_low_addr = req_addr[LOW_W-1:0];

  burst_seq #(
    .BEATS(BEATS),
    .IDX_W(IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_crit (req_crit),
    .bus_ack  (bus_ack),
    .bus_binh (bus_binh),
    .bus_err  (bus_err),
    .state    (state),
    .accept   (accept),
    .in_beat  (in_beat),
    .beat_done(beat_done),
    .term_err (term_err),
    .fallback (fallback),
    .last_beat(last_beat),
    .burst_on (burst_on),
    .word_idx (word_idx)
  );

  burst_dpath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .BEATS (BEATS),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .TAG_W (TAG_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_tag   (req_addr[ADDR_W-1:LOW_W]),
    .req_wdata (req_wdata),
    .beat_done (beat_done),
    .term_err  (term_err),
    .word_idx  (word_idx),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .line_rdata(line_rdata),
    .line_err  (line_err)
  );

  assign req_ready   = (state == ST_IDLE);
  assign line_done   = (state == ST_DONE);
  assign bus_valid   = in_beat;
  assign bus_burst_n = !(in_beat && burst_on);

  // R4
  first_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bus_valid && !bus_burst_n);

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack && !bus_err
    |=> bus_valid && $stable(bus_addr) && $stable(bus_burst_n)
        && $stable(bus_wdata) && $stable(bus_we));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid && bus_burst_n && !line_done);

  // R6
  single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback && !last_beat |=> !bus_valid ##1 bus_valid && bus_burst_n);

endmodule

// File: tb/burst_line_ctrl_tb.sv
`timescale 1ns/1ps
module burst_line_ctrl_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic         req_ready;
  logic [25:0]  req_addr;
  logic [1:0]   req_crit;
  logic [127:0] req_wdata;
  logic         line_done, line_err;
  logic [127:0] line_rdata;
  logic         bus_valid, bus_burst_n, bus_we;
  logic [25:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         bus_ack, bus_binh, bus_err;

  always #4 clk = ~clk;

  burst_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_crit(req_crit), .req_wdata(req_wdata),
    .line_done(line_done), .line_err(line_err), .line_rdata(line_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_burst_n(bus_burst_n),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_binh(bus_binh), .bus_err(bus_err)
  );

  integer checks = 0, fails = 0;
  // scenario configuration written by the driving task
  int           issue = 0, taken = 0, served = 0;
  bit           c_we, c_noise;
  logic [25:0]  c_addr;
  int           c_crit, c_wait, c_mode, c_errb;
  logic [127:0] c_wdata;
  // reference model state: 0 idle, 1 beat, 2 gap, 3 done
  int           ph = 0, k = 0, cr = 0, wcnt = 0;
  bit           burst = 0, we_m = 0, errf = 0;
  logic [21:0]  base;
  logic [31:0]  wd [4];
  logic [31:0]  rd [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int w;
      bit ack, inh, e;
      string tb;
      w = (cr + k) % 4;
      // compare outputs against the model
      chk(req_ready == (ph == 0), "R11", "req_ready", req_ready, ph == 0);
      chk(line_done == (ph == 3), "R11", "line_done", line_done, ph == 3);
      chk(bus_valid == (ph == 1), ph == 2 ? "R6" : "R4", "bus_valid", bus_valid, ph == 1);
      if (ph == 1) begin
        chk(bus_addr == {base, w[1:0], 2'b00}, wcnt > 0 ? "R5" : "R2 R3", "bus_addr",
            bus_addr, {base, w[1:0], 2'b00});
        tb = (c_mode >= 2) ? "R7" : (!burst ? "R6" : "R4");
        chk(bus_burst_n == !burst, tb, "bus_burst_n", bus_burst_n, !burst);
        chk(bus_we == we_m, "R9", "bus_we", bus_we, we_m);
        if (we_m) chk(bus_wdata == wd[w], "R9", "bus_wdata", bus_wdata, wd[w]);
      end else begin
        chk(bus_burst_n == 1'b1, ph == 2 ? "R6" : "R1", "bus_burst_n idle", bus_burst_n, 1);
      end
      if (ph == 3) begin
        chk(line_err == errf, "R10", "line_err", line_err, errf);
        if (!errf && !we_m)
          chk(line_rdata == {rd[3], rd[2], rd[1], rd[0]}, "R8", "line_rdata",
              line_rdata, {rd[3], rd[2], rd[1], rd[0]});
      end
      // drive inputs for the next edge and advance the model
      req_valid = 1'b0;
      bus_ack = 1'b0; bus_binh = 1'b0; bus_err = 1'b0;
      bus_rdata = $urandom;
      if (ph != 0 && c_noise) begin
        req_valid = 1'b1; req_write = $urandom; req_addr = $urandom;
        req_crit = $urandom; req_wdata = {$urandom, $urandom, $urandom, $urandom};
      end
      case (ph)
        0: if (taken != issue) begin
          taken = issue;
          req_valid = 1'b1; req_write = c_we; req_addr = c_addr;
          req_crit = c_crit[1:0]; req_wdata = c_wdata;
          base = c_addr[25:4]; cr = c_crit; we_m = c_we; errf = 0;
          burst = 1; k = 0; wcnt = 0; ph = 1;
          for (int i = 0; i < 4; i++) wd[i] = c_wdata[i*32 +: 32];
        end
        1: begin
          ack = (wcnt >= c_wait);
          case (c_mode)
            1: inh = (k == 0);
            2: inh = (k == 1) && ack;
            3: inh = (k == 0) && !ack;
            default: inh = 0;
          endcase
          e = ack && (k == c_errb);
          bus_ack = ack; bus_binh = inh; bus_err = e;
          if (e) begin
            errf = 1; ph = 3;
          end else if (ack) begin
            if (!we_m) rd[w] = bus_rdata;
            if (k == 0 && burst && inh) burst = 0;
            if (k == 3) ph = 3;
            else begin
              k++; wcnt = 0; ph = burst ? 1 : 2;
            end
          end else wcnt++;
        end
        2: ph = 1;
        default: begin ph = 0; served++; end
      endcase
    end
  end

  task automatic run_line(input bit we, input logic [25:0] a, input int crit,
                          input int wt, input int mode, input int eb, input bit nz);
    @(posedge clk);
    c_we = we; c_addr = a; c_crit = crit; c_wait = wt; c_mode = mode;
    c_errb = eb; c_noise = nz;
    c_wdata = {$urandom, $urandom, $urandom, $urandom};
    issue++;
    for (int t = 0; t < 200 && served != issue; t++) @(posedge clk);
    c_noise = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: cycles %0d expected below %0d", 150000, 150000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_crit = '0;
    req_wdata = '0; bus_rdata = '0; bus_ack = 0; bus_binh = 0; bus_err = 0;
    c_noise = 0; c_mode = 0; c_errb = -1; c_wait = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(bus_valid == 1'b0, "R1", "bus_valid in reset", bus_valid, 0);
    chk(bus_burst_n == 1'b1, "R1", "bus_burst_n in reset", bus_burst_n, 1);
    chk(line_done == 1'b0, "R1", "line_done in reset", line_done, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    run_line(0, 26'h0001230, 0, 0, 0, -1, 0);   // R3 R8 plain burst read
    run_line(0, 26'h0ABCDE7, 2, 2, 0, -1, 0);   // R2 R5 unaligned, waits
    run_line(1, 26'h1234569, 3, 1, 0, -1, 0);   // R9 write burst
    run_line(0, 26'h0000F0F, 1, 0, 1, -1, 0);   // R6 inhibit on first ack
    run_line(1, 26'h3FFFFF3, 2, 3, 1, -1, 0);   // R6 fallback write with waits
    run_line(0, 26'h0200004, 3, 0, 2, -1, 0);   // R7 inhibit on second beat
    run_line(0, 26'h0777770, 0, 2, 3, -1, 0);   // R7 inhibit only while waiting
    run_line(0, 26'h0456788, 1, 1, 0, 2, 0);    // R10 error mid line
    run_line(1, 26'h0111111, 0, 0, 1, 0, 0);    // R10 error beats ack and inhibit
    run_line(0, 26'h2222222, 2, 1, 0, -1, 1);   // R11 requests while busy ignored
    run_line(0, 26'h0101010, 3, 0, 1, 3, 0);    // R10 error on last single beat
    for (int n = 0; n < 30; n++)
      run_line($urandom, $urandom, $urandom % 4, $urandom % 3, $urandom % 4,
               ($urandom % 3 == 0) ? int'($urandom % 4) : -1, $urandom);
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule